// File: doc/BRIEF.md
# Converter Serial Readout Sequencer

This block is the digital control and serial port of a multichannel converter. It runs a cycle of three states that the converter owns: convert, sleep and data output. A timed stand-in takes the place of the conversion. It counts core clock cycles, and the count depends on the active oversampling ratio. When the count runs out, the stand-in latches a supplied 30-bit result. The block then waits in sleep until the host drops chip select, and shifts out a 32-bit status-and-result word. During the same transfer it captures an 8-bit configuration word from the host.

The host clocks the port with its own serial clock. This clock is sampled by the core clock, so the host must keep each serial clock level for at least two core cycles. Raising chip select during a read abandons the read and starts the next conversion at once. A read that runs its full length also starts the next conversion by itself. When chip select is low outside a read, the data line shows live conversion status. A configuration the host sends takes effect when the next conversion starts.

Top module: `readout_seq`

## Requirements
- R1: Reset puts the block in convert with the data output disabled and the default configuration. The busy flag is high in convert and low in sleep and data output.
- R2: Once a conversion ends, the block stays in sleep while chip select is high. The latched result is kept, even if the supplied result input changes.
- R3: While chip select is high, the output enable is low and serial clock edges have no effect.
- R4: The output word is sent MSB first. Bit 31 is the end-of-conversion flag and is 0 when the data is ready. Bit 30 is 0. Bits 29..0 are the latched result: bit 29 is the sign, bits 28..5 are the 24-bit value and bits 4..0 are the sub-LSB bits.
- R5: The data output changes only after a falling serial clock edge. The serial input is sampled on the rising edge.
- R6: After the 32nd falling edge of a read, a new conversion starts without any host action (busy rises).
- R7: Chip select rising during data output ends the read and starts a conversion on the next core cycle.
- R8: While chip select is low outside a read, the data output shows 1 during convert and 0 during sleep.
- R9: The first 8 serial input bits of a read form the configuration word, MSB first. Bit 7 is the enable, bits 6..5 select the channel pair, bit 4 selects the global reference, bits 3..1 are the ratio code (OSR = 32 << code) and bit 0 selects 2x mode. The word is applied only when all 8 bits arrived and the enable is 1. The reset configuration is pair 0, local reference, code 3 (OSR 256) and 1x mode.
- R10: A conversion lasts 40·OSR + 170 core cycles of busy high.
- R11: The configuration outputs change only when a conversion starts, never during a read or sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sckIn | input | 1 | Host serial clock |
| sdi | input | 1 | Serial configuration input |
| resultIn | input | 30 | Stand-in conversion result (sign, 24 bits, 5 sub-LSB bits) |
| sdoData | output | 1 | Serial data / status output value |
| sdoEn | output | 1 | Output enable for the three-state data pin |
| busy | output | 1 | High while converting |
| chanPair | output | 2 | Active channel pair |
| globalRef | output | 1 | Active global reference select |
| osrCode | output | 3 | Active oversampling ratio code |
| fastMode | output | 1 | Active 2x mode select |

## Verification
A wrong state register shows up at once on the busy flag or on the status level driven while chip select is low. A bit counter that is off by one shows up as a shifted word, or as busy rising one serial clock early or late, within the same read. A configuration that is applied too early changes the configuration outputs in the middle of a read. A wrong ratio decode shows up only when the following conversion ends, as a busy pulse of the wrong length.

// File: rtl/readout_pkg.sv
package readout_pkg;
  localparam int WORD_W      = 32;
  localparam int RES_W       = 30;
  localparam int CFG_BITS    = 8;
  localparam int CNT_W       = 18;
  localparam int OSR_BASE    = 32;
  localparam int CORE_MULT   = 40;
  localparam int CORE_OFFSET = 170;

  typedef struct packed {
    logic startConv;
    logic loadWord;
    logic shiftOut;
    logic captureBit;
    logic captureLast;
  } strobe_t;

  typedef struct packed {
    logic [1:0] pair;
    logic       globalRef;
    logic [2:0] osrCode;
    logic       fastMode;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{pair: 2'd0, globalRef: 1'b0, osrCode: 3'd3, fastMode: 1'b0};

  // Counter load value: conversion length minus one.
  function automatic logic [CNT_W-1:0] convLoad(input logic [2:0] code);
    int len;
    len = CORE_MULT * (OSR_BASE << code) + CORE_OFFSET - 1;
    return CNT_W'(len);
  endfunction
endpackage

// File: rtl/readout_ctrl.sv
module readout_ctrl
  import readout_pkg::*;
#(
  parameter int WIDTH = WORD_W,
  parameter int CAPN  = CFG_BITS
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sckIn,
  input  logic    convDone,
  output strobe_t stb,
  output logic    busy,
  output logic    inOut
);
  localparam int BC_W   = $clog2(WIDTH);
  localparam int CAP_LO = WIDTH - CAPN;

  typedef enum logic [1:0] {ST_CONV, ST_SLEEP, ST_OUT} state_t;

  state_t          state, stateNext;
  logic [BC_W-1:0] bitCnt;
  logic            sckPrev;
  logic            sckRise, sckFall;

  assign sckRise = sckIn & ~sckPrev;
  assign sckFall = ~sckIn & sckPrev;

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_CONV: if (convDone) begin
        stb.loadWord = 1'b1;
        stateNext    = ST_SLEEP;
      end
      ST_SLEEP: if (!csN) stateNext = ST_OUT;
      ST_OUT: begin
        if (csN) begin
          stb.startConv = 1'b1;
          stateNext     = ST_CONV;
        end else begin
          if (sckRise && (int'(bitCnt) >= CAP_LO)) begin
            stb.captureBit  = 1'b1;
            stb.captureLast = (int'(bitCnt) == CAP_LO);
          end
          if (sckFall) begin
            stb.shiftOut = 1'b1;
            if (bitCnt == '0) begin
              stb.startConv = 1'b1;
              stateNext     = ST_CONV;
            end
          end
        end
      end
      default: stateNext = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CONV;
      bitCnt  <= BC_W'(WIDTH - 1);
      sckPrev <= 1'b0;
    end else begin
      state   <= stateNext;
      sckPrev <= sckIn;
      if (stb.startConv)     bitCnt <= BC_W'(WIDTH - 1);
      else if (stb.shiftOut) bitCnt <= bitCnt - 1'b1;
    end
  end

  assign busy  = (state == ST_CONV);
  assign inOut = (state == ST_OUT);
endmodule

// File: rtl/readout_dp.sv
module readout_dp
  import readout_pkg::*;
#(
  parameter int WIDTH = WORD_W,
  parameter int RESW  = RES_W,
  parameter int CAPN  = CFG_BITS,
  parameter int CW    = CNT_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic            sdi,
  input  logic [RESW-1:0] resultIn,
  output logic            convDone,
  output logic [WIDTH-1:0] word,
  output cfg_t            cfgActive
);
  localparam int PAD_W = WIDTH - RESW;

  logic [CW-1:0]   convCnt;
  logic [CAPN-1:0] cfgShift;
  logic [CAPN-1:0] pendWord;
  logic            pendValid;
  cfg_t            cfgNext;

  // Enable bit is the MSB of the captured word; the rest maps onto cfg_t.
  always_comb begin
    cfgNext = cfgActive;
    if (pendValid && pendWord[CAPN-1]) cfgNext = cfg_t'(pendWord[CAPN-2:0]);
  end

  assign convDone = (convCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convCnt   <= convLoad(CFG_RESET.osrCode);
      cfgActive <= CFG_RESET;
      cfgShift  <= '0;
      pendWord  <= '0;
      pendValid <= 1'b0;
      word      <= '0;
    end else begin
      if (stb.startConv) begin
        convCnt   <= convLoad(cfgNext.osrCode);
        cfgActive <= cfgNext;
        pendValid <= 1'b0;
      end else if (!convDone) begin
        convCnt <= convCnt - 1'b1;
      end
      if (stb.captureBit) cfgShift <= {cfgShift[CAPN-2:0], sdi};
      if (stb.captureLast) begin
        pendWord  <= {cfgShift[CAPN-2:0], sdi};
        pendValid <= 1'b1;
      end
      if (stb.loadWord)      word <= {{PAD_W{1'b0}}, resultIn};
      else if (stb.shiftOut) word <= {word[WIDTH-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/readout_seq.sv
module readout_seq
  import readout_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sckIn,
  input  logic             sdi,
  input  logic [RES_W-1:0] resultIn,
  output logic             sdoData,
  output logic             sdoEn,
  output logic             busy,
  output logic [1:0]       chanPair,
  output logic             globalRef,
  output logic [2:0]       osrCode,
  output logic             fastMode
);
  strobe_t           stb;
  logic              convDone;
  logic              inOut;
  logic [WORD_W-1:0] word;
  cfg_t              cfgActive;

  readout_ctrl #(.WIDTH(WORD_W), .CAPN(CFG_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sckIn(sckIn), .convDone(convDone),
    .stb(stb), .busy(busy), .inOut(inOut)
  );

  readout_dp #(.WIDTH(WORD_W), .RESW(RES_W), .CAPN(CFG_BITS), .CW(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdi(sdi), .resultIn(resultIn),
    .convDone(convDone), .word(word), .cfgActive(cfgActive)
  );

  assign sdoEn     = ~csN;
  assign sdoData   = inOut ? word[WORD_W-1] : busy;
  assign chanPair  = cfgActive.pair;
  assign globalRef = cfgActive.globalRef;
  assign osrCode   = cfgActive.osrCode;
  assign fastMode  = cfgActive.fastMode;
endmodule

// File: rtl/readout_chk.sv
module readout_chk (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        busy,
  input logic        inOut,
  input logic        sdoEn,
  input logic        sdoData,
  input logic [31:0] word,
  input logic [6:0]  cfgBus
);
  p_hiz_r3: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sdoEn);

  p_busy_excl_r1: assert property (@(posedge clk) disable iff (!rstN) busy |-> !inOut);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rstN) (inOut && csN) |=> busy);

  p_status_r8: assert property (@(posedge clk) disable iff (!rstN) (!csN && busy) |-> sdoData);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !inOut && $past(!busy && !inOut)) |-> $stable(word));

  p_cfg_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(busy) |-> $stable(cfgBus));
endmodule

bind readout_seq readout_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .busy(busy), .inOut(inOut),
  .sdoEn(sdoEn), .sdoData(sdoData), .word(word),
  .cfgBus({chanPair, globalRef, osrCode, fastMode})
);

// File: tb/tb_readout_seq.sv
module tb_readout_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sckIn = 1'b0;
  logic        sdi = 1'b0;
  logic [29:0] resultIn = '0;
  logic        sdoData, sdoEn, busy, globalRef, fastMode;
  logic [1:0]  chanPair;
  logic [2:0]  osrCode;

  int tests = 0;
  int fails = 0;
  logic [6:0] cfgModel;
  logic [29:0] expRes;

  always #2 clk = ~clk;

  readout_seq dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sckIn(sckIn), .sdi(sdi), .resultIn(resultIn),
    .sdoData(sdoData), .sdoEn(sdoEn), .busy(busy), .chanPair(chanPair),
    .globalRef(globalRef), .osrCode(osrCode), .fastMode(fastMode)
  );

  function automatic int expLen(input logic [2:0] code);
    return 40 * (32 << code) + 170;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] cfgPorts();
    return {chanPair, globalRef, osrCode, fastMode};
  endfunction

  // Count busy-high negedges starting at the current negedge.
  task automatic measureBusy(output int n);
    n = 0;
    while (busy === 1'b1 && n < 200000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Wait for sleep, disturb inputs with chip select high, then read nbits.
  task automatic doRead(input int nbits, input logic [7:0] cfgByte);
    logic [31:0] got, expWord;
    logic [6:0]  cfgBefore;
    bit          edgeOk, cfgOk;
    int          len;
    expWord = {2'b00, expRes};
    resultIn = 30'($urandom);                 // R2: result input changes in sleep
    for (int k = 0; k < 3; k++) begin         // R3: clock edges with cs high
      sckIn = 1'b1; repeat (2) @(negedge clk);
      sckIn = 1'b0; repeat (2) @(negedge clk);
    end
    check(sdoEn == 1'b0, "R3 sdoEn low while cs high", 32'(sdoEn), 0);
    check(busy == 1'b0, "R2 stays in sleep while cs high", 32'(busy), 0);
    cfgBefore = cfgPorts();
    csN = 1'b0;
    repeat (2) @(negedge clk);
    check(sdoEn == 1'b1, "R3 sdoEn high with cs low", 32'(sdoEn), 1);
    got = '0; edgeOk = 1'b1; cfgOk = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      got[31-i] = sdoData;
      sdi = (i < 8) ? cfgByte[7-i] : 1'($urandom);
      sckIn = 1'b1; repeat (2) @(negedge clk);
      if (sdoData !== got[31-i]) edgeOk = 1'b0;
      if (cfgPorts() !== cfgBefore) cfgOk = 1'b0;
      sckIn = (i == nbits - 1 && nbits < 32) ? 1'b1 : 1'b0;
      if (i != nbits - 1) repeat (2) @(negedge clk);
    end
    if (nbits < 32) begin
      csN = 1'b1;                             // abort
      @(negedge clk);
      check(busy == 1'b1 && sdoEn == 1'b0, "R7 abort starts conversion", {busy, sdoEn}, 32'b10);
      sckIn = 1'b0;
    end else begin
      @(negedge clk);
      check(busy == 1'b1, "R6 conversion restarts after 32 bits", 32'(busy), 1);
    end
    check(edgeOk, "R5 output steady across rising edge", 32'(edgeOk), 1);
    check(cfgOk, "R11 config unchanged during read", 32'(cfgOk), 1);
    if (nbits == 32)
      check(got == expWord, "R4 word format", got, expWord);
    else
      check((got >> (32 - nbits)) == (expWord >> (32 - nbits)), "R4 partial word", got, expWord);
    if (nbits >= 8 && cfgByte[7]) cfgModel = cfgByte[6:0];
    check(cfgPorts() == cfgModel, "R9 config applied at conversion start", 32'(cfgPorts()), 32'(cfgModel));
    expRes = resultIn;
    if (nbits == 32) begin
      // cs still low: status shows conversion in progress
      check(sdoData == 1'b1, "R8 status high during conversion", 32'(sdoData), 1);
      csN = 1'b1;
    end
    measureBusy(len);
    check(len == expLen(cfgModel[3:1]), "R10 conversion length", len, expLen(cfgModel[3:1]));
    csN = 1'b0; @(negedge clk);
    csN = 1'b1;
    // the cs-low pulse above starts a read; leaving it aborts into conversion
    @(negedge clk);
    measureBusy(len);
    expRes = resultIn;
  endtask

  initial begin
    int len;
    logic [7:0] cb;
    void'($urandom(32'h1234_5a5a));
    cfgModel = 7'b00_0_011_0;
    resultIn = 30'h2AB_CDEF;
    expRes = resultIn;
    repeat (3) @(negedge clk);
    check(busy == 1'b1 && sdoEn == 1'b0, "R1 reset state", {busy, sdoEn}, 32'b10);
    check(cfgPorts() == cfgModel, "R9 reset configuration", 32'(cfgPorts()), 32'(cfgModel));
    rstN = 1'b1;
    measureBusy(len);
    check(len == expLen(3'd3), "R10 first conversion length", len, expLen(3'd3));
    check(busy == 1'b0, "R1 busy low in sleep", 32'(busy), 0);
    csN = 1'b0; @(negedge clk); @(negedge clk);
    check(sdoData == 1'b0, "R8 status low when done", 32'(sdoData), 0);
    csN = 1'b1; @(negedge clk);
    measureBusy(len);                         // aborted read, default config kept
    check(len == expLen(3'd3), "R7 abort restarts with same config", len, expLen(3'd3));
    expRes = resultIn;
    doRead(32, 8'b1_10_1_000_1);              // enable, code 0
    doRead(32, 8'b0_01_0_001_0);              // enable low: ignored
    doRead(5, 8'b1_11_1_001_1);               // too short: ignored
    doRead(12, 8'b1_01_1_001_0);              // long enough abort: applied
    for (int t = 0; t < 8; t++) begin
      cb = 8'($urandom);
      cb[3:2] = 2'b00;                        // keep codes 0..1
      doRead(($urandom % 3 == 0) ? 9 + int'($urandom % 20) : 32, cb);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule